// File: doc/BRIEF.md
# Chainable Serial Configuration Memory Reader

This block is the read side of a configuration memory that hands out its contents one word per clock and can be strung into a chain with identical devices. An internal address counter walks a small synchronous word array from address 0 up to a parameterised terminal count. Each active clock edge delivers the word at the current address and advances the counter. Once the last word has been delivered the counter parks one step beyond the terminal count and does not roll over. The data pins then float and an active-low cascade output is pulled low to enable the next device in the chain.

Two control inputs govern the reader: an active-low chip enable and a combined output-enable/reset line that is active high for output and low for reset. Dropping either one floats the data pins at once, keeps the cascade output high and clears the counter to address 0 on the next clock edge. A deasserted chip enable also raises a standby flag. The array contents are loaded through a simple synchronous write port. The data pins are driven through a tri-state wrapper, and the drive enable is also brought out as a separate pin.

When devices are chained, the cascade output of one device feeds the chip enable of the next, and their data pins share a bus. The combined stream carries every word of the first array, then one idle cycle, then every word of the second array, and then floats.

Top module: `cfgrd_seq`

## Requirements
- R1: While oe_rst is high and ce_n is low, each rising clock edge with the address at or below LAST presents the word at that address on q_pin with q_drv high, and advances the address by one. After a reset, the k-th such edge (counting from 1) presents word k-1.
- R2: After the edge that presents word LAST, the address stays at LAST+1 for as long as both controls stay active. It never wraps back to word 0.
- R3: Whenever q_drv is high, cas_n is high.
- R4: With both controls active, once the address is past LAST and no word is being presented, q_drv is low and cas_n is low. This starts on the clock edge that follows the edge that presented word LAST.
- R5: While oe_rst is low, q_drv is low and cas_n is high at once, whatever the level of ce_n. The address is cleared to 0 on each such edge.
- R6: While ce_n is high, q_drv is low, cas_n is high and stby is high at once. The address is cleared to 0 on each such edge. stby is low whenever ce_n is low.
- R7: When reading resumes after a reset by either control, the first word presented is word 0.
- R8: A rising edge with wr_en high stores wr_data at wr_addr. Later reads of that address return the new value.
- R9: Two devices chained through cas_n into ce_n deliver all words of the first device, one idle cycle, all words of the second device, and then leave the bus floating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| oe_rst | input | 1 | High enables output; low floats data and clears the address |
| ce_n | input | 1 | Active-low chip enable; high floats data, clears the address and signals standby |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | AW | Array write address |
| wr_data | input | DW | Array write data |
| q_pin | output | DW | Tri-stated data output |
| q_drv | output | 1 | High while q_pin is driven |
| cas_n | output | 1 | Active-low cascade enable for the next device |
| stby | output | 1 | Standby flag, high while ce_n is high |

## Verification
The counter assertions assume that oe_rst goes low before the first clock edge, so the address starts from a cleared value, and that ce_n changes only between clock edges. The bench holds oe_rst low during preload and makes every input change on the falling edge. The assertions also assume the array is not written while it is being read. Because of this, the bench performs all writes, including the rewrite in the directed test, with oe_rst low.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

  // Address after one active edge: advance while within range, then park.
  function automatic int unsigned step_addr(int unsigned cur, int unsigned last);
    if (cur <= last) return cur + 1;
    return cur;
  endfunction

  // True while the address still points at a stored word.
  function automatic logic addr_in_range(int unsigned cur, int unsigned last);
    return cur <= last;
  endfunction

endpackage

// File: rtl/cfgrd_addr_ctr.sv
module cfgrd_addr_ctr #(
  parameter int unsigned LAST = 15,
  parameter int unsigned CW   = 5
) (
  input  logic          clk,
  input  logic          oe_rst,
  input  logic          run,
  output logic [CW-1:0] addr,
  output logic          in_range
);
  logic [CW-1:0] addr_q;
  logic [CW-1:0] addr_nx;

  always_comb begin
    addr_nx = CW'(cfgrd_pkg::step_addr(32'(addr_q), LAST));
  end

  always_ff @(posedge clk) begin
    if (!run) addr_q <= '0;
    else      addr_q <= addr_nx;
  end

  assign addr     = addr_q;
  assign in_range = cfgrd_pkg::addr_in_range(32'(addr_q), LAST);

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (!oe_rst)
    (run && in_range) |=> (addr_q == $past(addr_q) + CW'(1)));

  // R2
  park_hold_chk: assert property (@(posedge clk) disable iff (!oe_rst)
    (run && !in_range) |=> $stable(addr_q));

  // R2
  addr_bound_chk: assert property (@(posedge clk) disable iff (!oe_rst)
    addr_q <= CW'(LAST + 1));

  // R5
  reset_clr_chk: assert property (@(posedge clk)
    !oe_rst |=> (addr_q == '0));
endmodule

// File: rtl/cfgrd_array.sv
module cfgrd_array #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (32'(rd_addr) < DEPTH) rd_q <= mem[rd_addr];
    else                      rd_q <= '0;
  end
endmodule

// File: rtl/cfgrd_out_ctl.sv
module cfgrd_out_ctl (
  input  logic clk,
  input  logic oe_rst,
  input  logic ce_n,
  input  logic in_range,
  output logic run,
  output logic drv,
  output logic cas_n,
  output logic stby
);
  logic word_vld;
  logic past_end;

  assign run      = oe_rst && !ce_n;
  assign past_end = run && !in_range;

  always_ff @(posedge clk) begin
    word_vld <= run && in_range;
  end

  assign drv   = run && word_vld;
  assign cas_n = !(past_end && !word_vld);
  assign stby  = ce_n;

  // R3
  drv_cas_chk: assert property (@(posedge clk) disable iff (!oe_rst)
    drv |-> cas_n);

  // R4
  hand_off_chk: assert property (@(posedge clk) disable iff (!oe_rst)
    (run && $past(run) && !in_range && !$past(in_range)) |-> (!drv && !cas_n));

  // R6
  standby_chk: assert property (@(posedge clk) disable iff (!oe_rst)
    ce_n |-> (cas_n && !drv && stby));

  // R5
  oe_float_chk: assert property (@(posedge clk)
    !oe_rst |-> (cas_n && !drv));
endmodule

// File: rtl/cfgrd_seq.sv
module cfgrd_seq #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LAST  = DEPTH - 1,
  parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          oe_rst,
  input  logic          ce_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] q_pin,
  output logic          q_drv,
  output logic          cas_n,
  output logic          stby
);
  localparam int unsigned CW = AW + 1;

  logic [CW-1:0] addr;
  logic          in_range;
  logic          run;
  logic          drv;
  logic [DW-1:0] rd_q;

  cfgrd_out_ctl u_ctl (
    .clk      (clk),
    .oe_rst   (oe_rst),
    .ce_n     (ce_n),
    .in_range (in_range),
    .run      (run),
    .drv      (drv),
    .cas_n    (cas_n),
    .stby     (stby)
  );

  cfgrd_addr_ctr #(.LAST(LAST), .CW(CW)) u_ctr (
    .clk      (clk),
    .oe_rst   (oe_rst),
    .run      (run),
    .addr     (addr),
    .in_range (in_range)
  );

  cfgrd_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr[AW-1:0]),
    .rd_q    (rd_q)
  );

  assign q_drv = drv;
  assign q_pin = drv ? rd_q : 'z;

  // R6
  stby_pin_chk: assert property (@(posedge clk) disable iff (!oe_rst)
    !ce_n |-> !stby);
endmodule

// File: tb/sim_cfgrd_seq.sv
module sim_cfgrd_seq;
  localparam int unsigned DW = 8;
  localparam int unsigned D  = 4;
  localparam int unsigned AW = 2;
  localparam int NROW = 16;

  // row: {oe, cen, drv0, idx0[1:0], cas0, drv1, idx1[1:0], cas1}
  localparam logic [9:0] TBL [NROW] = '{
    10'b0_0_0_00_1_0_00_1, // 0 reset
    10'b1_0_1_00_1_0_00_1, // 1 R1 R7 word0
    10'b1_0_1_01_1_0_00_1, // 2
    10'b1_0_1_10_1_0_00_1, // 3
    10'b1_0_1_11_1_0_00_1, // 4 last word
    10'b1_0_0_00_0_0_00_1, // 5 R4 idle hand-off
    10'b1_0_0_00_0_1_00_1, // 6 R9 dev1 word0
    10'b1_0_0_00_0_1_01_1, // 7
    10'b1_0_0_00_0_1_10_1, // 8
    10'b1_0_0_00_0_1_11_1, // 9
    10'b1_0_0_00_0_0_00_0, // 10 chain done
    10'b1_0_0_00_0_0_00_0, // 11 R2 no wrap
    10'b0_0_0_00_1_0_00_1, // 12 R5
    10'b1_0_1_00_1_0_00_1, // 13 R7
    10'b1_1_0_00_1_0_00_1, // 14 R6
    10'b1_0_1_00_1_0_00_1  // 15 R7 after ce reset
  };

  logic clk = 1'b0;
  logic oe_rst, ce_n, wr_en0, wr_en1;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] q0, q1;
  logic drv0, drv1, cas0, cas1, stby0, stby1;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfgrd_seq #(.DW(DW), .DEPTH(D)) u0 (
    .clk(clk), .oe_rst(oe_rst), .ce_n(ce_n), .wr_en(wr_en0),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .q_pin(q0), .q_drv(drv0), .cas_n(cas0), .stby(stby0));

  cfgrd_seq #(.DW(DW), .DEPTH(D)) u1 (
    .clk(clk), .oe_rst(oe_rst), .ce_n(cas0), .wr_en(wr_en1),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .q_pin(q1), .q_drv(drv1), .cas_n(cas1), .stby(stby1));

  function automatic logic [DW-1:0] word_of(int dev, int idx);
    return DW'(8'h5A ^ (dev * 8'h40) ^ (idx * 8'h13 + 1));
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic oe, logic cen);
    @(negedge clk);
    oe_rst = oe; ce_n = cen;
    @(posedge clk);
    #1;
  endtask

  task automatic load(int dev, int idx, logic [DW-1:0] val);
    @(negedge clk);
    wr_addr = AW'(idx); wr_data = val;
    wr_en0 = (dev == 0); wr_en1 = (dev == 1);
    @(posedge clk);
    #1;
    wr_en0 = 1'b0; wr_en1 = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    oe_rst = 1'b0; ce_n = 1'b0; wr_en0 = 1'b0; wr_en1 = 1'b0;
    wr_addr = '0; wr_data = '0;
    for (int dv = 0; dv < 2; dv++)
      for (int i = 0; i < int'(D); i++) load(dv, i, word_of(dv, i)); // R8 preload

    for (int r = 0; r < NROW; r++) begin
      logic [9:0] e;
      e = TBL[r];
      step(e[9], e[8]);
      check("R5/R6", $sformatf("row%0d drv0", r), int'(drv0), int'(e[7]));
      check("R4", $sformatf("row%0d cas0", r), int'(cas0), int'(e[4]));
      check("R9", $sformatf("row%0d drv1", r), int'(drv1), int'(e[3]));
      check("R9", $sformatf("row%0d cas1", r), int'(cas1), int'(e[0]));
      check("R6", $sformatf("row%0d stby0", r), int'(stby0), int'(e[8]));
      if (e[7]) check("R1", $sformatf("row%0d q0", r), int'(q0), int'(word_of(0, int'(e[6:5]))));
      if (e[3]) check("R9", $sformatf("row%0d q1", r), int'(q1), int'(word_of(1, int'(e[2:1]))));
    end

    // R8: rewrite one word while in reset, then read it back
    step(1'b0, 1'b0);
    load(0, 1, 8'hC3);
    step(1'b1, 1'b0);
    check("R7", "word0 after rewrite", int'(q0), int'(word_of(0, 0)));
    step(1'b1, 1'b0);
    check("R8", "rewritten word1", int'(q0), 32'hC3);
    check("R8", "rewritten drv", int'(drv0), 1);

    // R5: oe low with ce high floats and keeps cascade high
    step(1'b0, 1'b1);
    check("R5", "drv oe low ce high", int'(drv0), 0);
    check("R5", "cas oe low ce high", int'(cas0), 1);
    check("R6", "stby oe low ce high", int'(stby0), 1);

    // R2: long run past end keeps floating, no wrap to word0
    step(1'b1, 1'b0);
    for (int i = 0; i < int'(D) + 3; i++) step(1'b1, 1'b0);
    check("R2", "no wrap drv", int'(drv0), 0);
    check("R2", "no wrap cas", int'(cas0), 0);

    // R5: drop oe mid-stream floats immediately (before the edge)
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    @(negedge clk);
    oe_rst = 1'b0;
    #1;
    check("R5", "combinational float", int'(drv0), 0);
    check("R5", "combinational cas", int'(cas0), 1);
    @(posedge clk);
    #1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule